// File: doc/BRIEF.md
# Power-Save Entry and Wake-Up Controller

This block sits beside the instruction issue stage of a 64-bit server core. It watches each issued instruction for one of four power-save requests: doze, nap, sleep and deep winkle. A well-formed request issued in hypervisor state halts the core, stops instruction fetch and sets a power-save flag. The block also raises a one-cycle pulse telling the machine-state logic to turn on the external-interrupt enable, so that a wake-up interrupt can be delivered. A malformed request raises an illegal-instruction fault. A request issued outside hypervisor state raises a privilege fault. In both fault cases the core keeps running.

Every exception the core takes passes through the block, which returns the vector offset and the saved-status word one cycle later. If the core was halted, the block ends power-save. A machine check keeps its own vector. Every other cause goes to the system-reset vector, with a 4-bit wake-up reason placed in the saved-status word. The saved-status word always reports a return from the shallowest state, because no architectural state is actually lost.

Top module: `pwrsave_ctrl`

## Requirements
- R1: A power-save request must meet all of the following:
  - bits [31:26] of `insn_word` equal 0x13;
  - bits [5:1] equal 0x12;
  - bits [10:6] hold 0x0C, 0x0D, 0x0E or 0x0F, giving `pm_kind` 0 (doze), 1 (nap), 2 (sleep) or 3 (deep winkle).

  Any other instruction word produces no output event.
- R2: A request with any bit set under mask 0x03FFF801 gives a one-cycle `fault_illegal` pulse one cycle after issue. The core does not halt. This check takes priority over the privilege check.
- R3: A well-formed request issued with `hv_mode` low gives a one-cycle `fault_priv` pulse one cycle after issue. The core does not halt.
- R4: A well-formed request issued with `hv_mode` high does all of the following one cycle after issue, until the core wakes:
  - `halted` goes to 1;
  - `fetch_en` goes to 0;
  - `ee_force` pulses for one cycle;
  - `pm_kind` holds the request kind.

  After reset, `halted` is 0, `fetch_en` is 1 and no pulse output is active.
- R5: While `halted` is 1, `insn_valid` is ignored.
- R6: An exception presented with `exc_valid` while halted clears `halted` one cycle later. In that same cycle it pulses `res_valid` with `res_srr1` = `msr_in` OR bit 16. Bit 16 is big-endian bit 47, the "resumed from the shallowest state" flag.
- R7: The exception ids are reset=0, machine check=1, external=2, decrementer=3, doorbell=4, hypervisor doorbell=5, hypervisor maintenance=6 and program=7. A machine-check wake keeps vector 0x200 and adds no reason code.
- R8: Any other supported wake is redirected to vector 0x100, with a reason code ORed into `res_srr1` bits [21:18]; bit 18 is big-endian bit 45. The codes are:

  | Cause | Code |
  |---|---|
  | Reset | 0x4 |
  | External | 0x8 |
  | Decrementer | 0x6 |
  | Doorbell | 0x5 |
  | Hypervisor doorbell | 0x3 |
  | Hypervisor maintenance | 0xA |

- R9: Any other exception id during power-save pulses `wake_err` together with `res_valid`. It gives vector 0x100, no reason code and a cleared `halted`.
- R10: An exception taken while not halted returns that exception's own vector and `res_srr1` equal to `msr_in`. The vectors are:

  | Exception | Vector |
  |---|---|
  | Reset | 0x100 |
  | Machine check | 0x200 |
  | External | 0x500 |
  | Program | 0x700 |
  | Decrementer | 0x900 |
  | Doorbell | 0xA00 |
  | Hypervisor doorbell | 0xE80 |
  | Hypervisor maintenance | 0xEA0 |

- R11: If `exc_valid` and `insn_valid` are high in the same cycle, the exception is handled and the instruction is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | An instruction is issued this cycle |
| insn_word | input | 32 | Issued instruction word |
| hv_mode | input | 1 | Core is in hypervisor state |
| exc_valid | input | 1 | An exception is taken this cycle |
| exc_id | input | 4 | Exception identifier (R7 encoding) |
| msr_in | input | 64 | Current machine-state value |
| halted | output | 1 | Power-save flag; core halted |
| fetch_en | output | 1 | Instruction fetch permitted |
| pm_kind | output | 2 | Kind of the last power-save entry |
| ee_force | output | 1 | Pulse: force interrupt enable on |
| fault_priv | output | 1 | Pulse: privilege fault |
| fault_illegal | output | 1 | Pulse: malformed power-save request |
| res_valid | output | 1 | Pulse: exception result valid |
| res_vector | output | 16 | Vector offset to take |
| res_srr1 | output | 64 | Saved-status word |
| wake_err | output | 1 | Pulse: unsupported wake-up cause |

## Verification
The bench wakes the core with every supported cause and with a machine check. A design with a wrong code, or a code in the wrong bits, shows a mismatched saved-status word; one that redirects machine checks shows vector 0x100 in place of 0x200. It issues instructions during power-save and in the same cycle as an exception; a design that keeps fetching would re-enter power-save or emit an unexpected pulse. It sends requests that carry both a reserved bit and a missing privilege, and sends a program exception during power-save. These catch a reversed fault priority and an unsupported cause that goes unflagged.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int XLEN       = 64;
    localparam int IW         = 32;
    localparam int VEC_W      = 16;
    localparam int CAUSE_W    = 4;
    localparam int KIND_N     = 4;
    localparam int KIND_W     = $clog2(KIND_N);
    localparam int SEL_W      = 5;

    localparam logic [5:0]    PRIMARY_OP = 6'h13;
    localparam logic [4:0]    SUB_OP     = 5'h12;
    localparam logic [SEL_W-1:0] SEL_BASE = 5'h0C;
    localparam logic [IW-1:0] RSV_MASK   = 32'h03FF_F801;

    // big-endian positions converted to little-endian indices
    localparam int WAKE_BIT  = XLEN - 1 - 47;
    localparam int CAUSE_LSB = XLEN - 1 - 45;

    localparam logic [VEC_W-1:0] RESET_VEC = 16'h0100;

    typedef enum logic [3:0] {
        EXC_RESET    = 4'd0,
        EXC_MCHECK   = 4'd1,
        EXC_EXTERNAL = 4'd2,
        EXC_DECR     = 4'd3,
        EXC_DBELL    = 4'd4,
        EXC_HV_DBELL = 4'd5,
        EXC_HV_MAINT = 4'd6,
        EXC_PROGRAM  = 4'd7
    } exc_id_e;

    typedef struct packed {
        logic              halted;
        logic [KIND_W-1:0] kind;
        logic              ee_force;
        logic              fault_priv;
        logic              fault_ill;
        logic              res_valid;
        logic [VEC_W-1:0]  res_vec;
        logic [XLEN-1:0]   res_srr1;
        logic              wake_err;
    } pm_state_t;
endpackage

// File: rtl/pm_decode.sv
module pm_decode
    import pm_pkg::*;
(
    input  logic [IW-1:0]     insn,
    output logic              is_pm,
    output logic              rsv_bad,
    output logic [KIND_W-1:0] kind
);
    logic              base_ok;
    logic [KIND_N-1:0] hit;

    assign base_ok = (insn[31:26] == PRIMARY_OP) && (insn[5:1] == SUB_OP);

    for (genvar k = 0; k < KIND_N; k++) begin : g_sel
        assign hit[k] = base_ok && (insn[10:6] == SEL_W'(int'(SEL_BASE) + k));
    end

    always_comb begin
        kind = '0;
        for (int k = 0; k < KIND_N; k++) begin
            if (hit[k]) kind = KIND_W'(k);
        end
    end

    assign is_pm   = |hit;
    assign rsv_bad = |(insn & RSV_MASK);
endmodule

// File: rtl/pm_wake_map.sv
module pm_wake_map
    import pm_pkg::*;
(
    input  logic [3:0]         exc_id,
    output logic [VEC_W-1:0]   own_vec,
    output logic [CAUSE_W-1:0] cause,
    output logic               is_mcheck,
    output logic               supported
);
    always_comb begin
        own_vec   = '0;
        cause     = '0;
        supported = 1'b1;
        is_mcheck = 1'b0;
        case (exc_id)
            EXC_RESET:    begin own_vec = 16'h0100; cause = 4'h4; end
            EXC_MCHECK:   begin own_vec = 16'h0200; is_mcheck = 1'b1; end
            EXC_EXTERNAL: begin own_vec = 16'h0500; cause = 4'h8; end
            EXC_DECR:     begin own_vec = 16'h0900; cause = 4'h6; end
            EXC_DBELL:    begin own_vec = 16'h0A00; cause = 4'h5; end
            EXC_HV_DBELL: begin own_vec = 16'h0E80; cause = 4'h3; end
            EXC_HV_MAINT: begin own_vec = 16'h0EA0; cause = 4'hA; end
            EXC_PROGRAM:  begin own_vec = 16'h0700; supported = 1'b0; end
            default:      begin supported = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pwrsave_ctrl.sv
module pwrsave_ctrl
    import pm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [31:0]       insn_word,
    input  logic              hv_mode,
    input  logic              exc_valid,
    input  logic [3:0]        exc_id,
    input  logic [63:0]       msr_in,
    output logic              halted,
    output logic              fetch_en,
    output logic [1:0]        pm_kind,
    output logic              ee_force,
    output logic              fault_priv,
    output logic              fault_illegal,
    output logic              res_valid,
    output logic [15:0]       res_vector,
    output logic [63:0]       res_srr1,
    output logic              wake_err
);
    pm_state_t st_d, st_q;

    logic              dec_is_pm;
    logic              dec_rsv_bad;
    logic [KIND_W-1:0] dec_kind;
    logic [VEC_W-1:0]  map_vec;
    logic [CAUSE_W-1:0] map_cause;
    logic              map_mcheck;
    logic              map_supported;

    pm_decode u_decode (
        .insn    (insn_word),
        .is_pm   (dec_is_pm),
        .rsv_bad (dec_rsv_bad),
        .kind    (dec_kind)
    );

    pm_wake_map u_map (
        .exc_id    (exc_id),
        .own_vec   (map_vec),
        .cause     (map_cause),
        .is_mcheck (map_mcheck),
        .supported (map_supported)
    );

    always_comb begin
        st_d            = st_q;
        st_d.ee_force   = 1'b0;
        st_d.fault_priv = 1'b0;
        st_d.fault_ill  = 1'b0;
        st_d.res_valid  = 1'b0;
        st_d.wake_err   = 1'b0;
        if (exc_valid) begin
            st_d.res_valid = 1'b1;
            if (st_q.halted) begin
                st_d.halted   = 1'b0;
                st_d.res_srr1 = msr_in | (XLEN'(1) << WAKE_BIT);
                if (map_mcheck) begin
                    st_d.res_vec = map_vec;
                end else if (map_supported) begin
                    st_d.res_vec  = RESET_VEC;
                    st_d.res_srr1 = st_d.res_srr1 | (XLEN'(map_cause) << CAUSE_LSB);
                end else begin
                    st_d.res_vec  = RESET_VEC;
                    st_d.wake_err = 1'b1;
                end
            end else begin
                st_d.res_vec  = map_vec;
                st_d.res_srr1 = msr_in;
            end
        end else if (insn_valid && !st_q.halted && dec_is_pm) begin
            if (dec_rsv_bad) begin
                st_d.fault_ill = 1'b1;
            end else if (!hv_mode) begin
                st_d.fault_priv = 1'b1;
            end else begin
                st_d.halted   = 1'b1;
                st_d.kind     = dec_kind;
                st_d.ee_force = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign halted        = st_q.halted;
    assign fetch_en      = !st_q.halted;
    assign pm_kind       = st_q.kind;
    assign ee_force      = st_q.ee_force;
    assign fault_priv    = st_q.fault_priv;
    assign fault_illegal = st_q.fault_ill;
    assign res_valid     = st_q.res_valid;
    assign res_vector    = st_q.res_vec;
    assign res_srr1      = st_q.res_srr1;
    assign wake_err      = st_q.wake_err;
endmodule

// File: rtl/pwrsave_ctrl_chk.sv
module pwrsave_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_valid,
    input logic        hv_mode,
    input logic        exc_valid,
    input logic [63:0] msr_in,
    input logic        halted,
    input logic        ee_force,
    input logic        fault_priv,
    input logic        fault_illegal,
    input logic        res_valid,
    input logic [15:0] res_vector,
    input logic [63:0] res_srr1,
    input logic        wake_err
);
    AST_ENTRY_NEEDS_HV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(hv_mode) && $past(insn_valid) && ee_force); // R4

    AST_PRIV_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_priv |-> !halted && !$past(hv_mode)); // R3

    AST_ILLEGAL_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_illegal |-> !halted); // R2

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !exc_valid |=> halted); // R5

    AST_WAKE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && $past(halted) |-> res_srr1[16] && !halted); // R6

    AST_UNSUPPORTED_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        wake_err |-> res_valid && res_vector == 16'h0100); // R9

    AST_AWAKE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !$past(halted) |-> res_srr1 == $past(msr_in)); // R10

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ee_force, fault_priv, fault_illegal, res_valid})); // R11
endmodule

bind pwrsave_ctrl pwrsave_ctrl_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .insn_valid    (insn_valid),
    .hv_mode       (hv_mode),
    .exc_valid     (exc_valid),
    .msr_in        (msr_in),
    .halted        (halted),
    .ee_force      (ee_force),
    .fault_priv    (fault_priv),
    .fault_illegal (fault_illegal),
    .res_valid     (res_valid),
    .res_vector    (res_vector),
    .res_srr1      (res_srr1),
    .wake_err      (wake_err)
);

// File: tb/pwrsave_ctrl_tb_top.sv
module pwrsave_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        hv_mode = 1'b0;
    logic        exc_valid = 1'b0;
    logic [3:0]  exc_id = '0;
    logic [63:0] msr_in = '0;
    logic        halted, fetch_en, ee_force, fault_priv, fault_illegal;
    logic        res_valid, wake_err;
    logic [1:0]  pm_kind;
    logic [15:0] res_vector;
    logic [63:0] res_srr1;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // event kinds: 1 entry, 2 privilege fault, 3 illegal fault, 4 exception result
    typedef struct {
        int          typ;
        logic [1:0]  kind;
        logic [15:0] vec;
        logic [63:0] srr1;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    pwrsave_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .hv_mode(hv_mode), .exc_valid(exc_valid), .exc_id(exc_id), .msr_in(msr_in),
        .halted(halted), .fetch_en(fetch_en), .pm_kind(pm_kind), .ee_force(ee_force),
        .fault_priv(fault_priv), .fault_illegal(fault_illegal), .res_valid(res_valid),
        .res_vector(res_vector), .res_srr1(res_srr1), .wake_err(wake_err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_insn(input logic [4:0] sel, input logic [31:0] rsv);
        return {6'h13, 15'b0, sel, 5'h12, 1'b0} | rsv;
    endfunction

    function automatic logic [63:0] wake_word(input logic [63:0] m, input logic [3:0] code);
        return m | (64'd1 << 16) | ({60'd0, code} << 18);
    endfunction

    task automatic push(input int typ, input logic [1:0] kind, input logic [15:0] vec,
                        input logic [63:0] srr1, input logic err, input string tag);
        exp_t e;
        e.typ = typ; e.kind = kind; e.vec = vec; e.srr1 = srr1; e.err = err; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic do_insn(input logic [31:0] w, input logic hv, input int typ,
                           input logic [1:0] kind, input string tag);
        if (typ != 0) push(typ, kind, '0, '0, 1'b0, tag);
        @(negedge clk);
        insn_word = w; hv_mode = hv; insn_valid = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    task automatic do_exc(input logic [3:0] id, input logic [63:0] m, input logic [15:0] vec,
                          input logic [63:0] srr1, input logic err, input string tag);
        push(4, 2'd0, vec, srr1, err, tag);
        @(negedge clk);
        exc_id = id; msr_in = m; exc_valid = 1'b1;
        @(negedge clk);
        exc_valid = 1'b0;
    endtask

    // monitor: pops the scoreboard whenever an output event appears
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int typ;
            typ = ee_force ? 1 : fault_priv ? 2 : fault_illegal ? 3 : res_valid ? 4 : 0;
            if (typ != 0) begin
                if (sb.size() == 0) begin
                    check(1'b0, "unexpected event R1/R5", 64'(typ), 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(typ == e.typ, {e.tag, " event"}, 64'(typ), 64'(e.typ));
                    if (e.typ == 1) begin
                        check(halted && !fetch_en && pm_kind == e.kind, {e.tag, " entry kind"},
                              64'(pm_kind), 64'(e.kind));
                    end else if (e.typ == 2 || e.typ == 3) begin
                        check(!halted, {e.tag, " no halt"}, 64'(halted), 64'd0);
                    end else if (e.typ == 4) begin
                        check(res_vector == e.vec, {e.tag, " vector"}, 64'(res_vector), 64'(e.vec));
                        check(res_srr1 == e.srr1, {e.tag, " srr1"}, res_srr1, e.srr1);
                        check(wake_err == e.err, {e.tag, " wake_err"}, 64'(wake_err), 64'(e.err));
                        check(!halted, {e.tag, " awake"}, 64'(halted), 64'd0);
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [3:0]  ids[6]   = '{4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6};
        logic [3:0]  codes[6] = '{4'h4, 4'h8, 4'h6, 4'h5, 4'h3, 4'hA};
        logic [63:0] m;
        repeat (3) @(negedge clk);
        // R4 reset state
        check(!halted && fetch_en && !ee_force && !res_valid && !fault_priv && !fault_illegal,
              "R4 reset state", {62'd0, halted, fetch_en}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 non-matching selector and other primary opcode are ignored
        do_insn(mk_insn(5'h08, 32'h0), 1'b1, 0, 2'd0, "R1 other selector");
        do_insn(32'h7C00_0324, 1'b1, 0, 2'd0, "R1 other opcode");
        check(!halted && fetch_en, "R1 no halt on non-request", 64'(halted), 64'd0);

        // R3 privilege fault
        do_insn(mk_insn(5'h0C, 32'h0), 1'b0, 2, 2'd0, "R3 doze without hv");
        // R2 reserved bits, including priority over privilege
        do_insn(mk_insn(5'h0D, 32'h0000_0800), 1'b1, 3, 2'd0, "R2 nap reserved bit 11");
        do_insn(mk_insn(5'h0E, 32'h0000_0001), 1'b0, 3, 2'd0, "R2 sleep bit0 priority");
        do_insn(mk_insn(5'h0F, 32'h0200_0000), 1'b1, 3, 2'd0, "R2 winkle bit25");
        check(!halted, "R2 still running", 64'(halted), 64'd0);

        // R10 exception while running
        do_exc(4'd3, 64'h8000_0000_0000_9033, 16'h0900, 64'h8000_0000_0000_9033, 1'b0, "R10 decrementer running");

        // R4/R5/R8 each supported cause, rotating kinds
        for (int i = 0; i < 6; i++) begin
            m = 64'h0000_0000_0000_1000 + 64'(i);
            do_insn(mk_insn(5'(12 + (i % 4)), 32'h0), 1'b1, 1, 2'(i % 4), "R4 entry");
            check(halted && !fetch_en, "R4 halted after entry", 64'(halted), 64'd1);
            do_insn(mk_insn(5'h0C, 32'h0), 1'b1, 0, 2'd0, "R5 insn while halted");
            do_insn(mk_insn(5'h0D, 32'h1), 1'b0, 0, 2'd0, "R5 bad insn while halted");
            check(halted && pm_kind == 2'(i % 4), "R5 state unchanged", 64'(pm_kind), 64'(i % 4));
            do_exc(ids[i], m, 16'h0100, wake_word(m, codes[i]), 1'b0, "R8 wake cause");
        end

        // R6 status bits already present are kept
        do_insn(mk_insn(5'h0D, 32'h0), 1'b1, 1, 2'd1, "R4 nap entry");
        m = 64'hFFFF_0000_0000_8001;
        do_exc(4'd2, m, 16'h0100, wake_word(m, 4'h8), 1'b0, "R6 wake keeps msr bits");

        // R7 machine check
        do_insn(mk_insn(5'h0E, 32'h0), 1'b1, 1, 2'd2, "R4 sleep entry");
        do_exc(4'd1, 64'h2, 16'h0200, 64'h2 | (64'd1 << 16), 1'b0, "R7 machine check wake");

        // R9 unsupported cause
        do_insn(mk_insn(5'h0F, 32'h0), 1'b1, 1, 2'd3, "R4 winkle entry");
        do_exc(4'd7, 64'h4, 16'h0100, 64'h4 | (64'd1 << 16), 1'b1, "R9 program during power-save");
        check(!halted, "R9 halted cleared", 64'(halted), 64'd0);

        // R10 after wake, normal routing again
        do_exc(4'd2, 64'h55, 16'h0500, 64'h55, 1'b0, "R10 external running");
        do_exc(4'd1, 64'h66, 16'h0200, 64'h66, 1'b0, "R10 mcheck running");

        // R11 simultaneous exception and request: exception only
        push(4, 2'd0, 16'h0E80, 64'h77, 1'b0, "R11 same-cycle exception");
        @(negedge clk);
        insn_word = mk_insn(5'h0C, 32'h0); hv_mode = 1'b1; insn_valid = 1'b1;
        exc_id = 4'd5; msr_in = 64'h77; exc_valid = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0; exc_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(!halted, "R11 request dropped", 64'(halted), 64'd0);
        check(sb.size() == 0, "R1 scoreboard drained", 64'(sb.size()), 64'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule